// File: doc/BRIEF.md
# Early-Aborting Fractional Divider

This unit divides one signed fixed-point fraction by another using a restoring shift-and-subtract loop that yields one quotient bit per clock. Each operand is a sign bit followed by a magnitude, and the binary point sits just above the top magnitude bit. A result can only be a proper fraction when the divisor is larger in magnitude than the dividend. The unit therefore spends its first cycle after accepting an operation comparing the two magnitudes. If the comparison fails, the operation stops there and reports overflow. This also covers division by zero.

When the check passes, the unit runs one restoring step per cycle for as many cycles as there are magnitude bits. It then presents a signed quotient and a signed remainder together with a one-cycle `done` pulse. Because an aborted operation finishes after the check cycle, the execution time depends on the operands. A client starts an operation by raising `start` while `busy` is low. It then waits for `done`, and the result stays on the outputs until the next `done`.

Top module: `frac_div`

## Requirements
- R1: Operands and results are W-bit sign-magnitude fractions (default W=18). Bit W-1 is the sign (1 = negative) and bits W-2:0 hold the magnitude m, whose value is m/2^(W-1).
- R2: `start` sampled high at a clock edge while `busy` is low accepts the operation. `busy` is high from the next cycle onward and falls in the same cycle that `done` rises.
- R3: If the divisor magnitude is less than or equal to the dividend magnitude, a zero divisor included, `done` and `ovf` are high together for one cycle. This happens in the second cycle after the accepting edge, with no quotient steps.
- R4: On overflow, `quotient` and `remainder` are both driven to all zeros.
- R5: Otherwise the quotient magnitude equals floor(|n|·2^(W-1)/|d|) and the remainder magnitude equals |n|·2^(W-1) − q·|d|, where |n| and |d| are the operand magnitudes.
- R6: The quotient sign bit is the XOR of the two operand sign bits. The remainder sign bit equals the dividend sign bit. Both apply even when the magnitude is zero.
- R7: A division that does not overflow raises `done` for exactly one cycle with `ovf` low. This happens W cycles after the accepting edge: one check cycle plus W-1 steps.
- R8: A `start` raised while `busy` is high is ignored. The running operation keeps its operands and timing.
- R9: `quotient` and `remainder` change only in a cycle where `done` is high and hold their value between such cycles.
- R10: Synchronous active-high reset clears `busy`, `done` and `ovf`, and sets `quotient` and `remainder` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a division |
| dividend | input | W | Dividend, sign-magnitude fraction |
| divisor | input | W | Divisor, sign-magnitude fraction |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| ovf | output | 1 | High with done when the quotient is not a proper fraction |
| quotient | output | W | Signed quotient fraction |
| remainder | output | W | Signed remainder, scaled by 2^-(W-1) |

## Verification
An overflowing operation reports two sampling points after `start` is seen with `busy` low, and a normal one reports W+1 sampling points after it. The monitor samples on the falling edge, notes the cycle in which each operation is accepted, and compares the measured distance to `done` against the value the scoreboard item expects for that operation. The ignored-start case is checked one cycle after the stray pulse, by looking at `busy`, and again when the original result emerges. The hold behaviour is checked several idle cycles after the last `done`.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int DEF_W = 18;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CHK  = 2'd1,
        ST_RUN  = 2'd2
    } st_e;

    typedef struct packed {
        logic num;
        logic quo;
    } sign_t;

endpackage

// File: rtl/frac_div_prep.sv
module frac_div_prep
    import frac_div_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output sign_t        sg,
    output logic [W-2:0] n_mag,
    output logic [W-2:0] d_mag
);
    // split sign and magnitude; quotient sign from the two operand signs
    always_comb begin
        sg.num = dividend[W-1];
        sg.quo = dividend[W-1] ^ divisor[W-1];
        n_mag  = dividend[W-2:0];
        d_mag  = divisor[W-2:0];
    end
endmodule

// File: rtl/frac_div_range.sv
module frac_div_range #(
    parameter int MW = 17
) (
    input  logic [MW-1:0] n_mag,
    input  logic [MW-1:0] d_mag,
    output logic          fits
);
    // a proper fraction needs a strictly larger divisor; zero divisor fails
    assign fits = (d_mag > n_mag);
endmodule

// File: rtl/frac_div_step.sv
module frac_div_step #(
    parameter int MW = 17
) (
    input  logic [MW-1:0] rem,
    input  logic [MW-1:0] d_mag,
    output logic [MW-1:0] rem_nx,
    output logic          qbit
);
    logic [MW:0]   shifted;
    logic [MW-1:0] diff;

    // partial remainder stays below d_mag, so the difference fits MW bits
    always_comb begin
        shifted = {rem, 1'b0};
        qbit    = (shifted >= {1'b0, d_mag});
        diff    = shifted[MW-1:0] - d_mag;
        rem_nx  = qbit ? diff : shifted[MW-1:0];
    end
endmodule

// File: rtl/frac_div.sv
module frac_div
    import frac_div_pkg::*;
#(
    parameter int W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         ovf,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int MW = W - 1;
    localparam int CW = $clog2(MW + 1);
    localparam int IW = $clog2(MW);

    st_e            st;
    logic [CW-1:0]  cnt;
    logic [MW-1:0]  rem_q;
    logic [MW-1:0]  dmag_q;
    logic [MW-1:0]  quo_q;
    sign_t          sg_q;

    sign_t          sg_in;
    logic [MW-1:0]  n_in;
    logic [MW-1:0]  d_in;
    logic           fits;
    logic [MW-1:0]  rem_nx;
    logic           qbit;
    logic [IW-1:0]  bit_idx;
    logic [MW-1:0]  quo_nx;

    frac_div_prep #(.W(W)) u_prep (
        .dividend (dividend),
        .divisor  (divisor),
        .sg       (sg_in),
        .n_mag    (n_in),
        .d_mag    (d_in)
    );

    frac_div_range #(.MW(MW)) u_range (
        .n_mag (rem_q),
        .d_mag (dmag_q),
        .fits  (fits)
    );

    frac_div_step #(.MW(MW)) u_step (
        .rem    (rem_q),
        .d_mag  (dmag_q),
        .rem_nx (rem_nx),
        .qbit   (qbit)
    );

    // quotient bits land MSB first at position cnt-1
    always_comb begin
        bit_idx         = IW'(cnt - CW'(1));
        quo_nx          = quo_q;
        quo_nx[bit_idx] = qbit;
    end

    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            rem_q     <= '0;
            dmag_q    <= '0;
            quo_q     <= '0;
            sg_q      <= '0;
            done      <= 1'b0;
            ovf       <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= 1'b0;
            ovf  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        rem_q  <= n_in;
                        dmag_q <= d_in;
                        sg_q   <= sg_in;
                        quo_q  <= '0;
                        st     <= ST_CHK;
                    end
                end
                ST_CHK: begin
                    if (!fits) begin
                        done      <= 1'b1;
                        ovf       <= 1'b1;
                        quotient  <= '0;
                        remainder <= '0;
                        st        <= ST_IDLE;
                    end else begin
                        cnt <= CW'(MW);
                        st  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_nx;
                    quo_q <= quo_nx;
                    cnt   <= cnt - CW'(1);
                    if (cnt == CW'(1)) begin
                        done      <= 1'b1;
                        quotient  <= {sg_q.quo, quo_nx};
                        remainder <= {sg_q.num, rem_nx};
                        st        <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frac_div_chk.sv
module frac_div_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-2:0] n_mag,
    input logic [W-2:0] d_mag,
    input logic         busy,
    input logic         done,
    input logic         ovf,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3
    abort_early_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy && (d_mag <= n_mag) |=> ##1 (done && ovf));

    // R3
    no_done_in_check_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> !done);

    // R3
    ovf_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> done);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder)));
endmodule

bind frac_div frac_div_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .n_mag     (dividend[W-2:0]),
    .d_mag     (divisor[W-2:0]),
    .busy      (busy),
    .done      (done),
    .ovf       (ovf),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/sim_frac_div.sv
`timescale 1ns/1ps
module sim_frac_div;
    localparam int W = 18;
    localparam int M = W - 1;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         ov;
        int           lat;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, ovf;
    logic [W-1:0] quotient, remainder;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    exp_t sb[$];
    int   acc_q[$];
    logic [W-1:0] last_q = '0;
    logic [W-1:0] last_r = '0;
    logic [31:0]  seed = 32'h1234_5678;

    always #10 clk = ~clk;

    frac_div #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .ovf(ovf),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic exp_t model(input logic [W-1:0] n, input logic [W-1:0] d);
        exp_t e;
        logic [M-1:0]   nm, dm;
        logic [2*M-1:0] num, qm, rm;
        nm = n[M-1:0];
        dm = d[M-1:0];
        if (dm <= nm) begin
            e.q = '0; e.r = '0; e.ov = 1'b1; e.lat = 2;
        end else begin
            num = {nm, {M{1'b0}}};
            qm  = num / {{M{1'b0}}, dm};
            rm  = num - qm * {{M{1'b0}}, dm};
            e.q = {n[W-1] ^ d[W-1], qm[M-1:0]};
            e.r = {n[W-1], rm[M-1:0]};
            e.ov = 1'b0;
            e.lat = W + 1;
        end
        return e;
    endfunction

    task automatic issue(input logic [W-1:0] n, input logic [W-1:0] d);
        @(posedge clk); #2;
        while (busy) begin
            @(posedge clk); #2;
        end
        dividend = n;
        divisor  = d;
        start    = 1'b1;
        sb.push_back(model(n, d));
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // monitor: scoreboard compare at falling edges
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (start && !busy) acc_q.push_back(cyc);
            if (done) begin
                if (sb.size() == 0 || acc_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    int   a;
                    e = sb.pop_front();
                    a = acc_q.pop_front();
                    chk(ovf == e.ov, "R3/R7 ovf", ovf, e.ov);
                    chk(quotient[M-1:0] == e.q[M-1:0], e.ov ? "R4 quotient" : "R5 quotient", quotient, e.q);
                    chk(remainder[M-1:0] == e.r[M-1:0], e.ov ? "R4 remainder" : "R5 remainder", remainder, e.r);
                    chk(quotient[W-1] == e.q[W-1] && remainder[W-1] == e.r[W-1], "R6 signs",
                        {quotient[W-1], remainder[W-1]}, {e.q[W-1], e.r[W-1]});
                    chk(cyc - a == e.lat, e.ov ? "R3 latency" : "R7 latency", cyc - a, e.lat);
                    chk(!busy, "R2 busy low at done", busy, 0);
                end
                last_q = quotient;
                last_r = remainder;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !ovf, "R10 flags", {busy, done, ovf}, 0);
        chk(quotient == '0 && remainder == '0, "R10 results", {quotient, remainder}, 0);

        // R5 / R1: 0.25 / 0.5 = 0.5
        issue(18'h08000, 18'h10000);
        // R6: sign combinations
        issue(18'h28000, 18'h10000);
        issue(18'h08000, 18'h30000);
        issue(18'h28000, 18'h30000);
        // R5: remainder left over, negative dividend
        issue(18'h20001, 18'h00003);
        // R3: equal magnitudes, zero divisor, zero by zero, larger dividend
        issue(18'h05555, 18'h25555);
        issue(18'h01234, 18'h20000);
        issue(18'h00000, 18'h00000);
        issue(18'h1FFFF, 18'h00001);
        // R5 / R6: zero dividend gives zero magnitude with XOR sign
        issue(18'h20000, 18'h00007);
        // boundary magnitudes
        issue(18'h00001, 18'h1FFFF);
        issue(18'h1FFFE, 18'h1FFFF);

        // R8: stray start while busy
        issue(18'h03000, 18'h07000);
        dividend = 18'h1FFFF;
        divisor  = 18'h00000;
        start    = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        @(negedge clk);
        chk(busy, "R8 busy kept", busy, 1);

        // mixed pseudo-random operands, back to back
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] n, d;
            seed = nxt(seed);
            n = seed[W-1:0];
            seed = nxt(seed);
            d = seed[W-1:0];
            if (i % 3 != 0) n[M-1:0] = n[M-1:0] >> (1 + (i % 5));
            issue(n, d);
        end

        while (sb.size() != 0) @(posedge clk);
        repeat (6) @(negedge clk);
        // R9 results hold when idle
        chk(quotient == last_q, "R9 quotient hold", quotient, last_q);
        chk(remainder == last_r, "R9 remainder hold", remainder, last_r);
        chk(!busy && !done, "R2 idle after drain", {busy, done}, 0);
        finish_up();
    end
endmodule